// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block takes four interrupt pins from outside the chip and turns each into a clean, per-line request for the interrupt controller behind it. Each pin is first synchronised into the core clock domain. A two-bit sense code then decides whether the line responds to a level (active high or active low) or to an edge (rising or falling). Edge events are held in a per-line pending latch until software clears them.

All configuration sits in one 32-bit control register on a minimal write/read port. The register holds the sense code and the enable bit for each line, a write-one-to-clear bit for each pending latch, a master enable that gates every line, and a routing bit that is passed straight out to the controller. Line 0 feeds the highest-priority (critical) group. Lines 1 to 3 are merged into one request for the middle (main) group. Arbitration between the groups is left to the logic downstream.

Top module: `ext_irq_conditioner`

## Requirements
- R1: After reset the control register reads 0x00000000, and all line requests, both group requests and the routing output are low.
- R2: A write stores these fields, and they read back as written: the sense code of line n at bits [23-2n:22-2n], the enable of line n at bit 11-n, the master enable at bit 12 and the routing bit at bit 0. The routing bit also drives crit_route_o. Every other bit reads as 0.
- R3: The clear bits (bit 27-n for line n) always read back as 0.
- R4: Sense code 0 (active-high level): the request of an enabled line follows its pin, two clock edges after the pin changes.
- R5: Sense code 3 (active-low level): the request of an enabled line is the inverse of its pin, two clock edges after the pin changes.
- R6: Sense code 1 (rising edge): a rising pin sets the line's pending latch, so its request rises three clock edges after the pin does. The request stays high after the pin falls.
- R7: Sense code 2 (falling edge): a falling pin sets the latch, three clock edges later. A rising pin has no effect.
- R8: Writing 1 to bit 27-n clears only the latch of line n. The request drops at the edge that takes the write.
- R9: If an edge is detected in the same cycle that its line is cleared, the latch stays set.
- R10: The enable bit 11-n gates the request of line n. Edges that arrive while the line is disabled are still latched, and they appear as soon as the line is enabled.
- R11: While the master enable (bit 12) is 0, all requests are low, whatever the pins and the other fields hold.
- R12: crit_req_o carries the request of line 0. main_req_o is the OR of the requests of lines 1 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ext_pin_i | input | 4 | Raw external interrupt pins, bit n is line n |
| ctrl_we_i | input | 1 | Write strobe for the control register |
| ctrl_wdata_i | input | 32 | Write data |
| ctrl_rdata_o | output | 32 | Control register read value |
| line_req_o | output | 4 | Conditioned request for each line |
| crit_req_o | output | 1 | Request to the critical group (line 0) |
| main_req_o | output | 1 | Request to the main group (lines 1 to 3) |
| crit_route_o | output | 1 | Critical routing control bit |

## Verification
A register write shows up in the read value and in every request that depends on it at the first clock edge after the strobe is sampled. A level-mode pin change reaches its request after two edges, because of the synchroniser. An edge-mode pin change needs three edges, because the pending latch adds one more. The bench drives inputs on the falling clock edge and counts rising edges to exactly these depths before it samples on a falling edge. In several places it also samples one edge early, to prove a request is not yet visible. For the clear race, the write strobe is placed in the single cycle in which the synchronised edge is being detected.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int LINES  = 4;
  localparam int CTRL_W = 32;

  // Fixed layout of the shared control register
  localparam int MASTER_BIT = 12;
  localparam int ROUTE_BIT  = 0;

  typedef enum logic [1:0] {
    SENSE_HIGH = 2'd0,
    SENSE_RISE = 2'd1,
    SENSE_FALL = 2'd2,
    SENSE_LOW  = 2'd3
  } sense_e;

  typedef struct packed {
    logic [LINES-1:0][1:0] sense;
    logic [LINES-1:0]      enable;
    logic                  master;
    logic                  route;
  } ctrl_t;

  function automatic int sense_lsb(input int n);
    return 22 - 2 * n;
  endfunction

  function automatic int enable_bit(input int n);
    return 11 - n;
  endfunction

  function automatic int clear_bit(input int n);
    return 27 - n;
  endfunction

endpackage

// File: rtl/ext_irq_pin_sync.sv
module ext_irq_pin_sync #(
  parameter int LINES  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin_i,
  output logic [LINES-1:0] level_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);

  localparam int TOP = STAGES - 1;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q, chain_d;
    logic              prev_q, prev_d;

    always_comb begin
      chain_d = {chain_q[TOP-1:0], pin_i[g]};
      prev_d  = chain_q[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= chain_d;
        prev_q  <= prev_d;
      end
    end

    assign level_o[g] = chain_q[TOP];
    assign rise_o[g]  = chain_q[TOP] & ~prev_q;
    assign fall_o[g]  = ~chain_q[TOP] & prev_q;

    // R6
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[g] |=> !rise_o[g]);
    // R7
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o[g] |=> !fall_o[g]);
  end

endmodule

// File: rtl/ext_irq_ctrl_regs.sv
module ext_irq_ctrl_regs
  import ext_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic [LINES-1:0]  clr_o,
  output logic [CTRL_W-1:0] rdata_o
);

  localparam int CLR_HI = clear_bit(0);
  localparam int CLR_LO = clear_bit(LINES - 1);

  ctrl_t ctrl_q, ctrl_d;
  logic  unused_wdata_bits;

  assign unused_wdata_bits = ^{wdata_i[31:28], wdata_i[15:13], wdata_i[7:1]};

  always_comb begin
    ctrl_d = ctrl_q;
    for (int n = 0; n < LINES; n++) begin
      ctrl_d.sense[n]  = wdata_i[sense_lsb(n) +: 2];
      ctrl_d.enable[n] = wdata_i[enable_bit(n)];
      clr_o[n]         = we_i & wdata_i[clear_bit(n)];
    end
    ctrl_d.master = wdata_i[MASTER_BIT];
    ctrl_d.route  = wdata_i[ROUTE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (we_i) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int n = 0; n < LINES; n++) begin
      rdata_o[sense_lsb(n) +: 2]  = ctrl_q.sense[n];
      rdata_o[enable_bit(n)]      = ctrl_q.enable[n];
    end
    rdata_o[MASTER_BIT] = ctrl_q.master;
    rdata_o[ROUTE_BIT]  = ctrl_q.route;
  end

  assign ctrl_o = ctrl_q;

  // R3
  clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o[CLR_HI:CLR_LO] == '0);
  // R2
  sense_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> rdata_o[23:16] == $past(wdata_i[23:16]));
  // R2
  gate_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> rdata_o[12:8] == $past(wdata_i[12:8]));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(rdata_o));

endmodule

// File: rtl/ext_irq_line.sv
module ext_irq_line
  import ext_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic [1:0] sense_i,
  input  logic       enable_i,
  input  logic       master_i,
  input  logic       clr_i,
  output logic       req_o
);

  logic hit;
  logic pend_q, pend_d, pend_en;
  logic cond;

  always_comb begin
    hit = ((sense_i == SENSE_RISE) && rise_i) ||
          ((sense_i == SENSE_FALL) && fall_i);
    pend_en = hit | clr_i;
    // a fresh edge has priority over a clear in the same cycle
    pend_d  = hit ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  always_comb begin
    unique case (sense_i)
      SENSE_HIGH: cond = level_i;
      SENSE_LOW:  cond = ~level_i;
      default:    cond = pend_q;
    endcase
    req_o = master_i & enable_i & cond;
  end

  // R9
  edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend_q);
  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hit) |=> !pend_q);
  // R6
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !hit) |=> $stable(pend_q));

endmodule

// File: rtl/ext_irq_conditioner.sv
module ext_irq_conditioner
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  ext_pin_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_rdata_o,
  output logic [LINES-1:0]  line_req_o,
  output logic              crit_req_o,
  output logic              main_req_o,
  output logic              crit_route_o
);

  logic [1:0]       rst_pipe_q;
  logic             rst_n_int;
  ctrl_t            ctrl;
  logic [LINES-1:0] clr;
  logic [LINES-1:0] level, rise, fall;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_pipe_q[1];

  ext_irq_ctrl_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .ctrl_o  (ctrl),
    .clr_o   (clr),
    .rdata_o (ctrl_rdata_o)
  );

  ext_irq_pin_sync #(
    .LINES  (LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .pin_i   (ext_pin_i),
    .level_o (level),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_cond
    ext_irq_line u_line (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .level_i  (level[g]),
      .rise_i   (rise[g]),
      .fall_i   (fall[g]),
      .sense_i  (ctrl.sense[g]),
      .enable_i (ctrl.enable[g]),
      .master_i (ctrl.master),
      .clr_i    (clr[g]),
      .req_o    (line_req_o[g])
    );

    // R10
    line_enable_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
      line_req_o[g] |-> ctrl_rdata_o[enable_bit(g)]);
  end

  assign crit_req_o   = line_req_o[0];
  assign main_req_o   = |line_req_o[LINES-1:1];
  assign crit_route_o = ctrl.route;

  // R11
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !ctrl_rdata_o[MASTER_BIT] |-> (line_req_o == '0));
  // R12
  main_group_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    main_req_o |-> (ctrl_rdata_o[MASTER_BIT] && (line_req_o[LINES-1:1] != '0)));

endmodule

// File: tb/sim_ext_irq_conditioner.sv
module sim_ext_irq_conditioner;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  pins;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  req;
  logic        crit, mainr, route;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ext_irq_conditioner u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_pin_i    (pins),
    .ctrl_we_i    (we),
    .ctrl_wdata_i (wdata),
    .ctrl_rdata_o (rdata),
    .line_req_o   (req),
    .crit_req_o   (crit),
    .main_req_o   (mainr),
    .crit_route_o (route)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Control word: sense n at [23-2n:22-2n], enable n at 11-n, master 12, route 0
  function automatic logic [31:0] cfg(input logic [1:0] s0, input logic [1:0] s1,
                                      input logic [1:0] s2, input logic [1:0] s3,
                                      input logic [3:0] en, input logic m);
    logic [31:0] v;
    v = '0;
    v[23:22] = s0; v[21:20] = s1; v[19:18] = s2; v[17:16] = s3;
    for (int n = 0; n < 4; n++) v[11-n] = en[n];
    v[12] = m;
    return v;
  endfunction

  // clear bit of line n is 27-n
  function automatic logic [31:0] clr(input logic [3:0] lines);
    logic [31:0] v;
    v = '0;
    for (int n = 0; n < 4; n++) v[27-n] = lines[n];
    return v;
  endfunction

  task automatic write_ctrl(input logic [31:0] v);
    we = 1'b1; wdata = v;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic t_reset;
    check("R1 rdata", rdata, 32'h0);
    check("R1 req", {28'h0, req}, 32'h0);
    check("R1 groups", {29'h0, crit, mainr, route}, 32'h0);
  endtask

  task automatic t_regs;
    write_ctrl(32'hFFFF_FFFF);
    check("R2 R3 readback all ones", rdata, 32'h00FF_1F01);
    check("R2 route out", {31'h0, route}, 32'h1);
    write_ctrl(32'h0F5A_1A01);
    check("R2 R3 readback pattern", rdata, 32'h005A_1A01);
    write_ctrl(32'h0);
    check("R2 route cleared", {31'h0, route}, 32'h0);
  endtask

  task automatic t_level_high;
    pins = 4'h0;
    write_ctrl(cfg(2'd0, 2'd0, 2'd0, 2'd0, 4'hF, 1'b1));
    tick(2);
    check("R4 idle", {28'h0, req}, 32'h0);
    pins = 4'b0101;
    tick(1);
    check("R4 not yet after one edge", {28'h0, req}, 32'h0);
    tick(1);
    check("R4 follows pin", {28'h0, req}, 32'h5);
    check("R12 both groups", {30'h0, crit, mainr}, 32'h3);
    pins = 4'h0;
    tick(2);
    check("R4 released", {28'h0, req}, 32'h0);
  endtask

  task automatic t_level_low;
    write_ctrl(cfg(2'd3, 2'd3, 2'd3, 2'd3, 4'hF, 1'b1));
    check("R5 low pins active", {28'h0, req}, 32'hF);
    pins = 4'b1000;
    tick(2);
    check("R5 inverse of pin", {28'h0, req}, 32'h7);
    pins = 4'hF;
    tick(2);
    check("R5 all high inactive", {28'h0, req}, 32'h0);
    pins = 4'h0;
    tick(2);
  endtask

  task automatic t_rise;
    write_ctrl(cfg(2'd0, 2'd1, 2'd0, 2'd0, 4'hF, 1'b1) | clr(4'hF));
    pins = 4'b0010;
    tick(2);
    check("R6 not yet latched", {28'h0, req}, 32'h0);
    tick(1);
    check("R6 latched", {28'h0, req}, 32'h2);
    pins = 4'h0;
    tick(3);
    check("R6 held after pin falls", {28'h0, req}, 32'h2);
    write_ctrl(cfg(2'd0, 2'd1, 2'd0, 2'd0, 4'hF, 1'b1) | clr(4'b0010));
    check("R8 cleared", {28'h0, req}, 32'h0);
  endtask

  task automatic t_fall;
    write_ctrl(cfg(2'd0, 2'd0, 2'd2, 2'd0, 4'b0100, 1'b1) | clr(4'hF));
    pins = 4'b0100;
    tick(3);
    check("R7 rising ignored", {28'h0, req}, 32'h0);
    pins = 4'h0;
    tick(3);
    check("R7 falling latched", {28'h0, req}, 32'h4);
    write_ctrl(cfg(2'd0, 2'd0, 2'd2, 2'd0, 4'b0100, 1'b1) | clr(4'b0100));
    check("R8 falling cleared", {28'h0, req}, 32'h0);
  endtask

  task automatic t_clear_select;
    write_ctrl(cfg(2'd1, 2'd1, 2'd1, 2'd1, 4'hF, 1'b1) | clr(4'hF));
    pins = 4'hF;
    tick(3);
    check("R6 all latched", {28'h0, req}, 32'hF);
    write_ctrl(cfg(2'd1, 2'd1, 2'd1, 2'd1, 4'hF, 1'b1) | clr(4'b0100));
    check("R8 only line 2 cleared", {28'h0, req}, 32'hB);
    check("R3 clear bits read 0", rdata & 32'h0F00_0000, 32'h0);
    pins = 4'h0;
    write_ctrl(cfg(2'd1, 2'd1, 2'd1, 2'd1, 4'hF, 1'b1) | clr(4'hF));
    check("R8 rest cleared", {28'h0, req}, 32'h0);
  endtask

  task automatic t_race;
    logic [31:0] base;
    base = cfg(2'd1, 2'd0, 2'd0, 2'd0, 4'b0001, 1'b1);
    write_ctrl(base | clr(4'hF));
    pins = 4'b0001;
    tick(3);
    check("R6 line 0 latched", {28'h0, req}, 32'h1);
    pins = 4'h0;
    tick(3);
    pins = 4'b0001;
    repeat (2) @(posedge clk);
    @(negedge clk);
    we = 1'b1; wdata = base | clr(4'b0001);
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; wdata = '0;
    check("R9 edge wins over clear", {28'h0, req}, 32'h1);
    tick(1);
    check("R9 still pending", {28'h0, req}, 32'h1);
    write_ctrl(base | clr(4'b0001));
    check("R8 plain clear", {28'h0, req}, 32'h0);
    pins = 4'h0;
    tick(3);
  endtask

  task automatic t_enable;
    write_ctrl(cfg(2'd0, 2'd0, 2'd0, 2'd1, 4'b0111, 1'b1) | clr(4'hF));
    pins = 4'b1000;
    tick(3);
    check("R10 disabled line quiet", {28'h0, req}, 32'h0);
    pins = 4'h0;
    tick(3);
    write_ctrl(cfg(2'd0, 2'd0, 2'd0, 2'd1, 4'b1111, 1'b1));
    check("R10 latched while disabled", {28'h0, req}, 32'h8);
    check("R12 main only", {30'h0, crit, mainr}, 32'h1);
    write_ctrl(cfg(2'd0, 2'd0, 2'd0, 2'd0, 4'hF, 1'b1) | clr(4'hF));
  endtask

  task automatic t_master;
    write_ctrl(cfg(2'd0, 2'd0, 2'd0, 2'd0, 4'hF, 1'b0));
    pins = 4'hF;
    tick(2);
    check("R11 master off", {28'h0, req}, 32'h0);
    check("R11 groups off", {30'h0, crit, mainr}, 32'h0);
    write_ctrl(cfg(2'd0, 2'd0, 2'd0, 2'd0, 4'hF, 1'b1));
    check("R11 master on", {28'h0, req}, 32'hF);
    pins = 4'b0001;
    tick(2);
    check("R12 critical only", {30'h0, crit, mainr}, 32'h2);
    pins = 4'h0;
    tick(2);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; pins = 4'h0; we = 1'b0; wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_regs();
    t_level_high();
    t_level_low();
    t_rise();
    t_fall();
    t_clear_select();
    t_race();
    t_enable();
    t_master();
    finish_run();
  end

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    finish_run();
  end

endmodule